// File: doc/BRIEF.md
# Dual Channel Match Timer

This block holds two independent up-counters that run off a shared clock. Each channel owns a prescaler, a count register that software may load at any time, a match register and a control register. While a channel runs, its prescaler issues a tick every (divide + 1) clock cycles, and each tick advances the count by one. When a tick brings the count to the match value, and match detection is enabled, the channel's sticky status bit sets. The channel's interrupt line follows that status bit, gated by the channel's interrupt enable.

Software uses the block as an event timer. It zeroes a channel's count, writes the desired delay in ticks into the match register, and then sets all three enable bits. When the interrupt arrives, it clears the status bit by writing a one to it and disables the channel. The counter does not stop at the match value. It keeps counting and wraps around, and it halts only when software clears the run bit.

The registers sit on a simple 32-bit bus with a valid strobe and a write flag. A read returns its data on the cycle after the request.

Top module: `dual_match_timer`

## Requirements
- R1: After synchronous reset, every register reads as 0 and both interrupt lines are low.
- R2: Registers sit at fixed byte offsets. Control is at 0x00 and 0x04, match at 0x18 and 0x1C, count at 0x48 and 0x4C, each pair listed as channel 0 then channel 1. Status is at 0x60. Read data appears on the cycle after the read request.
- R3: Control bit 0 is run, bit 1 is interrupt enable and bit 2 is match enable. Bits 31:16 hold the prescaler divide value. All other control bits read as 0.
- R4: A running channel advances its count once every (divide + 1) clock cycles. The first tick comes divide + 1 cycles after the run bit is written.
- R5: A write to a count register loads that value. When the write lands on a tick, the write wins and no increment happens on that cycle. A stopped channel's count holds.
- R6: With match enable set, the status bit sets on the tick that brings the count to the match value. From a count of 0, a match of 2 produces the event after exactly two ticks.
- R7: The count continues past the match value and wraps from 0xFFFFFFFF to 0. A match value of 0 is hit at that wrap.
- R8: Status bit n belongs to channel n and stays set until cleared. Writing 1 to bit n of the status register clears that bit, and writing 0 leaves it alone. Writing 0xFFFF clears every bit.
- R9: When a status set and a write-one-to-clear of the same bit fall on the same cycle, the bit ends up set.
- R10: Interrupt line n is registered and equals status bit n AND interrupt enable bit n as they stood on the previous cycle. Clearing the enable masks the line while the status bit stays set.
- R11: The two channels count, compare and flag independently of each other.
- R12: With match enable clear, a channel that runs through its match value does not set its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq | output | 2 | Per-channel interrupt lines |

## Verification
Two pairs of functions can fall on the same cycle:
- A match event and a software clear of the same status bit. The bench provokes this by arming a channel with a count of 0 and a match of 2, then timing a write of 1 to the status register so that it lands on the second tick. It judges the result by reading status back, which must show the bit still set. A second clear issued away from any tick must then empty the bit.
- A count load and a prescaler tick. The bench provokes this by writing the count register while the channel runs at full rate. It judges the result by stopping the channel one cycle later and reading the count, which must equal the loaded value plus one.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] CTRL_BASE  = 8'h00;
  localparam logic [ADDR_W-1:0] MATCH_BASE = 8'h18;
  localparam logic [ADDR_W-1:0] COUNT_BASE = 8'h48;
  localparam logic [ADDR_W-1:0] STAT_ADDR  = 8'h60;

  // control field positions
  localparam int unsigned RUN_BIT = 0;
  localparam int unsigned IE_BIT  = 1;
  localparam int unsigned ME_BIT  = 2;
  localparam int unsigned DIV_LSB = 16;

  // per-channel register addresses are 4 bytes apart
  function automatic logic [ADDR_W-1:0] ch_addr(logic [ADDR_W-1:0] base, int unsigned ch);
    return base + ADDR_W'(ch * 4);
  endfunction
endpackage

// File: rtl/dmt_prescaler.sv
module dmt_prescaler #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pre_q;
  logic             wrap;

  assign wrap = (pre_q == div);
  assign tick = run && wrap;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_q <= '0;
    end else if (wrap) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/dmt_channel.sv
module dmt_channel
  import dmt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic              match_we,
  input  logic              count_we,
  input  logic              clr_req,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] match_q,
  output logic [DATA_W-1:0] count_q,
  output logic              status_q,
  output logic              irq_q,
  output logic              run_o,
  output logic              ie_o
);
  logic             run_q, ie_q, me_q;
  logic [DIV_W-1:0] div_q;
  logic             tick;
  logic [DATA_W-1:0] cnt_inc;
  logic             hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      ie_q  <= 1'b0;
      me_q  <= 1'b0;
      div_q <= '0;
    end else if (ctrl_we) begin
      run_q <= wdata[RUN_BIT];
      ie_q  <= wdata[IE_BIT];
      me_q  <= wdata[ME_BIT];
      div_q <= wdata[DIV_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
    end else if (match_we) begin
      match_q <= wdata;
    end
  end

  dmt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (run_q),
    .div  (div_q),
    .tick (tick)
  );

  assign cnt_inc = count_q + 1'b1;

  // software load has priority over a tick
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (count_we) begin
      count_q <= wdata;
    end else if (tick) begin
      count_q <= cnt_inc;
    end
  end

  assign hit = tick && me_q && !count_we && (cnt_inc == match_q);

  // set beats clear
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
    end else if (hit) begin
      status_q <= 1'b1;
    end else if (clr_req) begin
      status_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= status_q && ie_q;
    end
  end

  always_comb begin
    ctrl_rd                    = '0;
    ctrl_rd[RUN_BIT]           = run_q;
    ctrl_rd[IE_BIT]            = ie_q;
    ctrl_rd[ME_BIT]            = me_q;
    ctrl_rd[DIV_LSB +: DIV_W]  = div_q;
  end

  assign run_o = run_q;
  assign ie_o  = ie_q;
endmodule

// File: rtl/dmt_regbus.sv
module dmt_regbus
  import dmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_valid,
  input  logic                          bus_write,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [NUM_CH-1:0]             wdata_lo,
  input  logic [NUM_CH-1:0][DATA_W-1:0] ctrl_rd,
  input  logic [NUM_CH-1:0][DATA_W-1:0] match_rd,
  input  logic [NUM_CH-1:0][DATA_W-1:0] count_rd,
  input  logic [NUM_CH-1:0]             status,
  output logic [NUM_CH-1:0]             ctrl_we,
  output logic [NUM_CH-1:0]             match_we,
  output logic [NUM_CH-1:0]             count_we,
  output logic [NUM_CH-1:0]             clr_vec,
  output logic [DATA_W-1:0]             bus_rdata
);
  logic wr, rd;
  logic [DATA_W-1:0] rd_next;

  assign wr = bus_valid && bus_write;
  assign rd = bus_valid && !bus_write;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign ctrl_we[g]  = wr && (bus_addr == ch_addr(CTRL_BASE,  g));
    assign match_we[g] = wr && (bus_addr == ch_addr(MATCH_BASE, g));
    assign count_we[g] = wr && (bus_addr == ch_addr(COUNT_BASE, g));
  end

  assign clr_vec = (wr && bus_addr == STAT_ADDR) ? wdata_lo : '0;

  always_comb begin
    rd_next = '0;
    if (bus_addr == STAT_ADDR) begin
      rd_next = DATA_W'(status);
    end
    for (int unsigned i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ch_addr(CTRL_BASE, i))  rd_next = ctrl_rd[i];
      if (bus_addr == ch_addr(MATCH_BASE, i)) rd_next = match_rd[i];
      if (bus_addr == ch_addr(COUNT_BASE, i)) rd_next = count_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import dmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0][DATA_W-1:0] ctrl_vec, match_vec, count_vec;
  logic [NUM_CH-1:0] stat_vec, ie_vec, run_vec;
  logic [NUM_CH-1:0] ctrl_we, match_we, count_we, clr_vec;

  dmt_regbus #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .wdata_lo  (bus_wdata[NUM_CH-1:0]),
    .ctrl_rd   (ctrl_vec),
    .match_rd  (match_vec),
    .count_rd  (count_vec),
    .status    (stat_vec),
    .ctrl_we   (ctrl_we),
    .match_we  (match_we),
    .count_we  (count_we),
    .clr_vec   (clr_vec),
    .bus_rdata (bus_rdata)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dmt_channel #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .ctrl_we  (ctrl_we[g]),
      .match_we (match_we[g]),
      .count_we (count_we[g]),
      .clr_req  (clr_vec[g]),
      .wdata    (bus_wdata),
      .ctrl_rd  (ctrl_vec[g]),
      .match_q  (match_vec[g]),
      .count_q  (count_vec[g]),
      .status_q (stat_vec[g]),
      .irq_q    (irq[g]),
      .run_o    (run_vec[g]),
      .ie_o     (ie_vec[g])
    );
  end
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_CH-1:0]             irq,
  input logic [NUM_CH-1:0]             status,
  input logic [NUM_CH-1:0]             ie,
  input logic [NUM_CH-1:0]             run,
  input logic [NUM_CH-1:0]             cnt_wr,
  input logic [NUM_CH-1:0]             clr,
  input logic [NUM_CH-1:0][DATA_W-1:0] count
);
  // R1
  reset_clean_chk: assert property (@(posedge clk)
    rst |=> (irq == '0 && status == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R8
    status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (status[g] && !clr[g]) |=> status[g]);

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
      !ie[g] |=> !irq[g]);

    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!run[g] && !cnt_wr[g]) |=> $stable(count[g]));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
      (run[g] && !cnt_wr[g]) |=>
        (count[g] == $past(count[g]) || count[g] == $past(count[g]) + 1'b1));
  end
endmodule

bind dual_match_timer dmt_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .irq    (irq),
  .status (stat_vec),
  .ie     (ie_vec),
  .run    (run_vec),
  .cnt_wr (count_we),
  .clr    (clr_vec),
  .count  (count_vec)
);

// File: tb/sim_dual_match_timer.sv
module sim_dual_match_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dual_match_timer u0 (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  localparam logic [7:0] A_CTRL0 = 8'h00, A_CTRL1 = 8'h04;
  localparam logic [7:0] A_MAT0  = 8'h18, A_MAT1  = 8'h1C;
  localparam logic [7:0] A_CNT0  = 8'h48, A_CNT1  = 8'h4C;
  localparam logic [7:0] A_STAT  = 8'h60;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end on a falling edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    chk("R1 irq after reset", 32'(irq), 32'h0);
    rd_chk("R1 ctrl0", A_CTRL0, 0);
    rd_chk("R1 ctrl1", A_CTRL1, 0);
    rd_chk("R1 match0", A_MAT0, 0);
    rd_chk("R1 count1", A_CNT1, 0);
    rd_chk("R1 status", A_STAT, 0);
  endtask

  task automatic t_regmap;
    wr(A_CTRL0, 32'hFFFF_FFF8);
    rd_chk("R3 ctrl undefined bits read 0", A_CTRL0, 32'hFFFF_0000);
    wr(A_MAT1, 32'h0000_1234);
    rd_chk("R2 match1 offset", A_MAT1, 32'h0000_1234);
    rd_chk("R2 match0 untouched", A_MAT0, 32'h0);
    wr(A_CNT1, 32'hABCD_0001);
    rd_chk("R2 count1 offset", A_CNT1, 32'hABCD_0001);
    wr(A_CTRL0, 0);
  endtask

  task automatic t_prescale;
    wr(A_CNT0, 0);
    wr(A_CTRL0, 32'h0003_0001);
    repeat (19) @(negedge clk);
    wr(A_CTRL0, 0);
    rd_chk("R4 divide by 4 over 20 cycles", A_CNT0, 5);
    wr(A_CNT0, 0);
    wr(A_CTRL0, 32'h0000_0001);
    repeat (19) @(negedge clk);
    wr(A_CTRL0, 0);
    rd_chk("R4 divide by 1 over 20 cycles", A_CNT0, 20);
    rd_chk("R11 idle channel 1 count unchanged", A_CNT1, 32'hABCD_0001);
    repeat (5) @(negedge clk);
    rd_chk("R5 stopped count holds", A_CNT0, 20);
  endtask

  task automatic t_count_write;
    wr(A_CTRL0, 32'h0000_0001);
    wr(A_CNT0, 32'h0000_1000);
    wr(A_CTRL0, 0);
    rd_chk("R5 load wins over tick", A_CNT0, 32'h0000_1001);
  endtask

  task automatic t_delta2;
    wr(A_STAT, 32'hFFFF);
    wr(A_CNT0, 0);
    wr(A_MAT0, 2);
    wr(A_CTRL0, 32'h7);
    @(negedge clk);
    chk("R6 no irq after first tick", 32'(irq[0]), 0);
    @(negedge clk);
    chk("R10 irq lags status by one cycle", 32'(irq[0]), 0);
    @(negedge clk);
    chk("R6 irq after two ticks", 32'(irq[0]), 1);
    rd_chk("R6 status bit0 set", A_STAT, 1);
    wr(A_CTRL0, 0);
    @(negedge clk);
    chk("R10 irq masked when enable cleared", 32'(irq[0]), 0);
    rd_chk("R8 status sticky after disable", A_STAT, 1);
  endtask

  task automatic t_w1c;
    wr(A_CNT1, 0);
    wr(A_MAT1, 1);
    wr(A_CTRL1, 32'h7);
    repeat (3) @(negedge clk);
    wr(A_CTRL1, 0);
    rd_chk("R11 both channels flagged", A_STAT, 3);
    wr(A_STAT, 0);
    rd_chk("R8 writing 0 keeps status", A_STAT, 3);
    wr(A_STAT, 2);
    rd_chk("R8 clear bit1 only", A_STAT, 1);
    wr(A_STAT, 32'hFFFF);
    rd_chk("R8 clear all", A_STAT, 0);
  endtask

  task automatic t_wrap;
    wr(A_CNT0, 32'hFFFF_FFFE);
    wr(A_MAT0, 0);
    wr(A_CTRL0, 32'h5);
    repeat (3) @(negedge clk);
    wr(A_CTRL0, 0);
    rd_chk("R7 count wraps", A_CNT0, 2);
    rd_chk("R7 match 0 hit at wrap", A_STAT, 1);
    chk("R10 no irq without enable", 32'(irq[0]), 0);
    wr(A_STAT, 32'hFFFF);
  endtask

  task automatic t_no_me;
    wr(A_CNT1, 0);
    wr(A_MAT1, 3);
    wr(A_CTRL1, 32'h3);
    repeat (10) @(negedge clk);
    wr(A_CTRL1, 0);
    rd_chk("R12 count passed match", A_CNT1, 11);
    rd_chk("R12 no status without match enable", A_STAT, 0);
    chk("R12 irq low", 32'(irq[1]), 0);
  endtask

  task automatic t_set_wins;
    wr(A_CNT0, 0);
    wr(A_MAT0, 2);
    wr(A_CTRL0, 32'h7);
    @(negedge clk);
    wr(A_STAT, 1);
    rd_chk("R9 set beats clear", A_STAT, 1);
    wr(A_STAT, 1);
    rd_chk("R9 later clear works", A_STAT, 0);
    wr(A_CTRL0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_prescale();
    t_count_write();
    t_delta2();
    t_w1c();
    t_wrap();
    t_no_me();
    t_set_wins();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule